// File: doc/BRIEF.md
# Line Switch State Controller

This block drives the eight switches of a subscriber-line access matrix. A 3-bit command picks one switch grouping: all open, normal talk, or one of four test-access arrangements. The command passes through a transparent latch before it is decoded. That latch is gated by a hold input: while hold is low the latch follows the command, and while hold is high it keeps its last value. The decoded grouping is registered on the system clock and leaves the block as an 8-bit drive vector. Bit i of that vector drives switch SW(i+1).

Two fault inputs override the decoder and open every switch:

- **Undervoltage lockout.** The lockout input is active high. While it is asserted, commands are not accepted.
- **Thermal shutdown.** The shutdown input is active low.

Both fault inputs arrive asynchronously and pass through a two-flop synchroniser.

After lockout releases, a power-up interlock keeps every switch open for as long as the hold input stays high. A board pull-up keeps that pin high while the driving logic is still unconfigured. Commands take effect only once hold has been driven low.

The control state machine has four states:

- `ST_LOCKOUT`: lockout is active, everything is open.
- `ST_ARM_WAIT`: lockout has released, and the machine waits for hold to go low.
- `ST_RUN`: the latched command drives the switches.
- `ST_THERMAL`: thermal shutdown is active, everything is open.

Its transitions:

- Reset enters `ST_LOCKOUT`.
- `ST_LOCKOUT` goes to `ST_ARM_WAIT` when the synchronised lockout is clear.
- `ST_ARM_WAIT` goes to `ST_RUN` when hold is low. If thermal shutdown is active at that moment, it goes to `ST_THERMAL` instead.
- `ST_RUN` goes to `ST_THERMAL` on synchronised thermal shutdown.
- `ST_THERMAL` goes back to `ST_RUN` when thermal shutdown clears.
- Every state goes to `ST_LOCKOUT` on synchronised lockout.

Top module: `line_switch_ctrl`

## Requirements
- R1: With hold low, each command code sets `sw_o` at the next clock edge, with bit i driving SW(i+1):
  - 001 (talk): SW1 and SW2, giving 8'h03.
  - 010 (input monitor): SW1, SW2, SW5 and SW6, giving 8'h33.
  - 011 (output monitor): SW1 through SW4, giving 8'h0F.
  - 100 (input and output test): SW3 through SW6, giving 8'h3C.
  - 101 (input bridge): SW5 through SW8, giving 8'h F0 (8'hF0).
- R2: Command codes 000, 110 and 111 all give `sw_o` = 8'h00.
- R3: While `latch_hold` is high, changes on `cmd_i` have no effect, and `sw_o` keeps the grouping of the last code captured while hold was low.
- R4: While `rst_n` is low, `sw_o` is 8'h00.
- R5: `sw_o` becomes 8'h00 within three clock edges of `uvlo_i` going high. It stays 8'h00 while lockout persists, whatever the command inputs do.
- R6: `sw_o` becomes 8'h00 within three clock edges of `tsd_n_i` going low. Three edges after `tsd_n_i` returns high, the latched grouping reappears without any re-arming.
- R7: After lockout releases, `sw_o` stays 8'h00 while `latch_hold` is high. The first clock edge with hold low loads the command and drives its grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Switch command code |
| latch_hold | input | 1 | Latch control: low = transparent, high = hold |
| uvlo_i | input | 1 | Undervoltage lockout, active high, asynchronous |
| tsd_n_i | input | 1 | Thermal shutdown, active low, asynchronous |
| sw_o | output | 8 | Switch drives, bit i closes SW(i+1) |

## Verification
The assertions are checked on every cycle and cover four behaviours:

- Only legal groupings appear on the outputs.
- The all-open codes open everything one edge after they are loaded.
- The latch never changes while hold is high.
- Three consecutive sampled cycles of lockout or shutdown leave every switch open, and no switch closes unless hold has been low since lockout last cleared.

Only the bench scenarios can show the rest:

- The exact edge at which a fault takes effect.
- The return to the latched grouping when shutdown clears.
- That a command changed during hold never reaches the outputs.
- The full mapping from each code to its switch pattern.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int unsigned NUM_SW     = 8;
    localparam int unsigned CODE_W     = 3;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef logic [NUM_SW-1:0] sw_mask_t;

    typedef enum logic [CODE_W-1:0] {
        CMD_OFF        = 3'd0,
        CMD_TALK       = 3'd1,
        CMD_TIN_MON    = 3'd2,
        CMD_TOUT_MON   = 3'd3,
        CMD_TIN_TOUT   = 3'd4,
        CMD_TIN_BRIDGE = 3'd5,
        CMD_RSV6       = 3'd6,
        CMD_RSV7       = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_LOCKOUT  = 2'd0,
        ST_ARM_WAIT = 2'd1,
        ST_RUN      = 2'd2,
        ST_THERMAL  = 2'd3
    } ctl_state_e;

    // switch pairs, bit i drives SW(i+1)
    localparam sw_mask_t GRP_BREAK  = 8'b0000_0011;
    localparam sw_mask_t GRP_TOUT   = 8'b0000_1100;
    localparam sw_mask_t GRP_TIN    = 8'b0011_0000;
    localparam sw_mask_t GRP_BRIDGE = 8'b1100_0000;
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lsc_cmd_latch.sv
module lsc_cmd_latch
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cmd_i,
    input  logic              hold_i,
    input  logic              block_i,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] q_o
);
    logic open_w;

    assign open_w = !hold_i && !block_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= CMD_OFF;
        else if (open_w) q_o <= cmd_i;
    end

    // transparent path while open, stored value otherwise
    assign code_o = open_w ? cmd_i : q_o;
endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output sw_mask_t          mask_o
);
    always_comb begin
        unique case (cmd_e'(code_i))
            CMD_TALK:       mask_o = GRP_BREAK;
            CMD_TIN_MON:    mask_o = GRP_BREAK | GRP_TIN;
            CMD_TOUT_MON:   mask_o = GRP_BREAK | GRP_TOUT;
            CMD_TIN_TOUT:   mask_o = GRP_TOUT  | GRP_TIN;
            CMD_TIN_BRIDGE: mask_o = GRP_TIN   | GRP_BRIDGE;
            CMD_OFF, CMD_RSV6, CMD_RSV7: mask_o = '0;
            default:        mask_o = '0;
        endcase
    end
endmodule

// File: rtl/lsc_fsm.sv
module lsc_fsm
    import lsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     uvlo_s,
    input  logic     tsd_s,
    input  logic     hold_i,
    input  sw_mask_t mask_i,
    output sw_mask_t sw_o
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKOUT:  state_d = uvlo_s ? ST_LOCKOUT : ST_ARM_WAIT;
            ST_ARM_WAIT: begin
                if (uvlo_s)       state_d = ST_LOCKOUT;
                else if (!hold_i) state_d = tsd_s ? ST_THERMAL : ST_RUN;
            end
            ST_RUN: begin
                if (uvlo_s)     state_d = ST_LOCKOUT;
                else if (tsd_s) state_d = ST_THERMAL;
            end
            ST_THERMAL: begin
                if (uvlo_s)      state_d = ST_LOCKOUT;
                else if (!tsd_s) state_d = ST_RUN;
            end
            default: state_d = ST_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKOUT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  sw_o <= '0;
        else if (state_d == ST_RUN)  sw_o <= mask_i;
        else                         sw_o <= '0;
    end
endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cmd_i,
    input  logic              latch_hold,
    input  logic              uvlo_i,
    input  logic              tsd_n_i,
    output logic [NUM_SW-1:0] sw_o
);
    logic [1:0]        flt_sync;
    logic              uvlo_s;
    logic              tsd_s;
    logic [CODE_W-1:0] lat_code;
    logic [CODE_W-1:0] lat_q;
    sw_mask_t          dec_mask;

    lsc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({uvlo_i, tsd_n_i}),
        .sync_o (flt_sync)
    );

    assign uvlo_s = flt_sync[1];
    assign tsd_s  = !flt_sync[0];

    lsc_cmd_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .hold_i (latch_hold),
        .block_i(uvlo_s),
        .code_o (lat_code),
        .q_o    (lat_q)
    );

    lsc_decode u_dec (
        .code_i(lat_code),
        .mask_o(dec_mask)
    );

    lsc_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .uvlo_s(uvlo_s),
        .tsd_s (tsd_s),
        .hold_i(latch_hold),
        .mask_i(dec_mask),
        .sw_o  (sw_o)
    );
endmodule

// File: rtl/line_switch_ctrl_chk.sv
module line_switch_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_i,
    input logic       latch_hold,
    input logic       uvlo_i,
    input logic       tsd_n_i,
    input logic [7:0] sw_o,
    input logic       uvlo_s,
    input logic [2:0] lat_q
);
    logic [1:0] uv_run;
    logic [1:0] ts_run;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_run <= 2'd0;
            ts_run <= 2'd0;
            armed  <= 1'b0;
        end else begin
            uv_run <= uvlo_i   ? ((uv_run == 2'd3) ? 2'd3 : uv_run + 2'd1) : 2'd0;
            ts_run <= !tsd_n_i ? ((ts_run == 2'd3) ? 2'd3 : ts_run + 2'd1) : 2'd0;
            if (uvlo_s)           armed <= 1'b0;
            else if (!latch_hold) armed <= 1'b1;
        end
    end

    a_r1_legal_group: assert property (@(posedge clk) disable iff (!rst_n)
        sw_o inside {8'h00, 8'h03, 8'h33, 8'h0F, 8'h3C, 8'hF0});

    a_r2_off_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_hold && (cmd_i == 3'd0 || cmd_i[2:1] == 2'b11)) |=> (sw_o == 8'h00));

    a_r3_hold_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hold |=> $stable(lat_q));

    a_r5_lockout_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_run == 2'd3) |-> (sw_o == 8'h00));

    a_r6_thermal_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_run == 2'd3) |-> (sw_o == 8'h00));

    a_r7_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_o != 8'h00) |-> armed);
endmodule

bind line_switch_ctrl line_switch_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .latch_hold(latch_hold),
    .uvlo_i    (uvlo_i),
    .tsd_n_i   (tsd_n_i),
    .sw_o      (sw_o),
    .uvlo_s    (uvlo_s),
    .lat_q     (lat_q)
);

// File: tb/line_switch_ctrl_bench.sv
module line_switch_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic       latch_hold = 1'b1;
    logic       uvlo_i = 1'b1;
    logic       tsd_n_i = 1'b1;
    logic [7:0] sw_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    line_switch_ctrl u_line_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .latch_hold(latch_hold),
        .uvlo_i(uvlo_i), .tsd_n_i(tsd_n_i), .sw_o(sw_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] grp(input logic [2:0] c);
        case (c)
            3'd1: return 8'h03;
            3'd2: return 8'h33;
            3'd3: return 8'h0F;
            3'd4: return 8'h3C;
            3'd5: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    // reference model built from the requirements
    logic       m_u1, m_u2, m_t1, m_t2;
    logic [2:0] m_q;
    int         m_st;   // 0 lockout, 1 waiting for hold low, 2 running
    logic [7:0] m_sw;

    always @(posedge clk) begin
        logic fu, ft;
        logic [2:0] code;
        int nst;
        if (!rst_n) begin
            m_u1 <= 1'b1; m_u2 <= 1'b1; m_t1 <= 1'b1; m_t2 <= 1'b1;
            m_q <= 3'd0; m_st <= 0; m_sw <= 8'h00;
        end else begin
            fu = m_u2;
            ft = !m_t2;
            code = (!latch_hold && !fu) ? cmd_i : m_q;
            if (m_st == 0)      nst = fu ? 0 : 1;
            else if (m_st == 1) nst = fu ? 0 : (!latch_hold ? 2 : 1);
            else                nst = fu ? 0 : 2;
            m_u1 <= uvlo_i; m_u2 <= m_u1; m_t1 <= tsd_n_i; m_t2 <= m_t1;
            if (!latch_hold && !fu) m_q <= cmd_i;
            m_st <= nst;
            m_sw <= (nst == 2 && !ft) ? grp(code) : 8'h00;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: sw_o actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk(tag, sw_o, m_sw);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5A17);
        // R4: reset state
        repeat (3) @(negedge clk);
        chk("R4", sw_o, 8'h00);
        rst_n = 1'b1;
        // R5: lockout held, commands ignored
        cmd_i = 3'd2; latch_hold = 1'b0;
        repeat (5) begin step("R5"); chk("R5", sw_o, 8'h00); end
        // R7: lockout released with hold high
        latch_hold = 1'b1; uvlo_i = 1'b0;
        repeat (6) begin step("R7"); chk("R7", sw_o, 8'h00); end
        latch_hold = 1'b0;
        step("R7"); chk("R7", sw_o, 8'h33);
        // R1 / R2: every code
        for (int c = 0; c < 8; c++) begin
            cmd_i = 3'(c);
            step((c == 0 || c > 5) ? "R2" : "R1");
            chk((c == 0 || c > 5) ? "R2" : "R1", sw_o, grp(3'(c)));
        end
        // R3: hold keeps last grouping
        cmd_i = 3'd3; step("R1"); chk("R1", sw_o, 8'h0F);
        latch_hold = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cmd_i = 3'(k + 4);
            step("R3"); chk("R3", sw_o, 8'h0F);
        end
        // R5: lockout timing
        uvlo_i = 1'b1;
        step("R5"); chk("R5", sw_o, 8'h0F);
        step("R5"); chk("R5", sw_o, 8'h0F);
        step("R5"); chk("R5", sw_o, 8'h00);
        uvlo_i = 1'b0;
        repeat (8) begin step("R7"); chk("R7", sw_o, 8'h00); end
        cmd_i = 3'd4; latch_hold = 1'b0;
        step("R7"); chk("R7", sw_o, 8'h3C);
        // R6: thermal shutdown and recovery
        tsd_n_i = 1'b0;
        step("R6"); chk("R6", sw_o, 8'h3C);
        step("R6"); chk("R6", sw_o, 8'h3C);
        step("R6"); chk("R6", sw_o, 8'h00);
        tsd_n_i = 1'b1;
        step("R6"); chk("R6", sw_o, 8'h00);
        step("R6"); chk("R6", sw_o, 8'h00);
        step("R6"); chk("R6", sw_o, 8'h3C);
        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            string tag;
            cmd_i = 3'($urandom % 8);
            latch_hold = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) uvlo_i = !uvlo_i;
            if (($urandom % 30) == 0) tsd_n_i = !tsd_n_i;
            if (m_st == 0)      tag = "R5";
            else if (m_st == 1) tag = "R7";
            else if (!m_t2)     tag = "R6";
            else                tag = "R1";
            step(tag);
        end
        finish_run();
    end
endmodule